// File: doc/BRIEF.md
# Serial SRAM Target with SPI Access

This block is a memory target that sits on a shared SPI bus and behaves like a small serial static RAM. A host selects it with an active-low chip select, clocks an 8-bit command into it, follows with a start address, and then moves any number of data words in or out. After each word the internal pointer moves on to the next location. The array inside is a single-port RAM. The data word width and the address width are compile-time parameters.

The serial pins are oversampled by the block's own clock. A two-stage synchronizer brings select, serial clock and serial input into the clock domain, and the edges of the serial clock are found from the synchronized copy. For this to work, each high phase and each low phase of the serial clock must last at least four periods of `clk`. The serial output comes with its own enable, so several such targets can share one data-out wire. Three commands are recognised: plain read, read with one dummy byte, and write. A transfer that runs past the top of the array reads zeros and drops writes. It does not wrap to address zero.

Top module: `spi_sram_target`

## Requirements
- R1: The 8-bit command and then the address are shifted in most significant bit first, with input bits taken on rising SCK edges. The address field is ceil(ADDR_W/8) bytes long, and field bits above ADDR_W are ignored, so with the defaults the field 0xFC05 selects location 0x005.
- R2: Command codes are 0x02 (write), 0x03 (read) and 0x0B (read with dummy byte). Any other code makes the block ignore the rest of the selected period: memory is not written and SO stays 0.
- R3: In a write, each group of WORD_W bits (MSB first) after the address is stored at the current location once its last bit has arrived.
- R4: Reads and writes are sequential. After every complete data word the location moves up by one, for as long as chip select stays low.
- R5: For code 0x03, the MSB of the first data word appears on SO after the falling SCK edge that follows the last address bit. No dummy clocks are inserted.
- R6: For code 0x0B, eight dummy SCK cycles follow the address, and the first data bit appears after the falling edge that ends the eighth dummy cycle.
- R7: SO is enabled (spi_so_oe = 1) while chip select is low and disabled while it is high.
- R8: SO changes only in response to a falling SCK edge while selected, so it is stable during every high SCK phase.
- R9: Once a transfer has moved past the last location (all ones), further writes are discarded, further reads return 0, and location 0 is left untouched.
- R10: Raising chip select at any point aborts the command. A partially received write word is discarded, and the next selection starts with a fresh command.
- R11: After reset, spi_so_oe is 0 and spi_so is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock used to oversample the serial pins |
| rst | input | 1 | Synchronous active-high reset |
| spi_cs_n | input | 1 | Chip select, active low |
| spi_sck | input | 1 | Serial clock from the host, mode 0 |
| spi_si | input | 1 | Serial data from the host |
| spi_so | output | 1 | Serial data to the host |
| spi_so_oe | output | 1 | Output enable for spi_so; low means released |

## Verification
Two events can land in the same clock cycle: the word-completing rising edge that stores a byte and steps the pointer, and the pointer reaching the top of the array. In that cycle the write must still go through while the next one is blocked. The bench provokes this by writing three bytes from location 0x3FE and reading three bytes back from the same start. The expected result is the first two bytes followed by a zero, with location 0 unchanged. A second collision is chip select rising partway through a write word while the word counter is still running. This is judged by reading the location back afterwards and finding its old value.

// File: rtl/spi_sram_pkg.sv
package spi_sram_pkg;

    localparam logic [7:0] CMD_WRITE = 8'h02;
    localparam logic [7:0] CMD_READ  = 8'h03;
    localparam logic [7:0] CMD_FREAD = 8'h0B;

    typedef enum logic [2:0] {
        PH_CMD,
        PH_ADDR,
        PH_DUMMY,
        PH_RDATA,
        PH_WDATA,
        PH_IGNORE
    } phase_e;

    // Synchronized view of the serial pins, one record per clock
    typedef struct packed {
        logic sel;
        logic rise;
        logic fall;
        logic din;
    } pin_evt_t;

    function automatic int addr_field_bytes(input int aw);
        return (aw + 7) / 8;
    endfunction

    function automatic int max3(input int a, input int b, input int c);
        int m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

    function automatic logic cmd_known(input logic [7:0] c);
        return (c == CMD_WRITE) || (c == CMD_READ) || (c == CMD_FREAD);
    endfunction

endpackage

// File: rtl/spi_sram_sync.sv
module spi_sram_sync
    import spi_sram_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     sck,
    input  logic     cs_n,
    input  logic     si,
    output pin_evt_t evt
);
    // bit 2: cs_n, bit 1: sck, bit 0: si
    logic [2:0] chain [STAGES];
    logic       sck_prev;

    always_ff @(posedge clk) begin
        if (rst) chain[0] <= 3'b100;
        else     chain[0] <= {cs_n, sck, si};
    end

    for (genvar g = 1; g < STAGES; g++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) chain[g] <= 3'b100;
            else     chain[g] <= chain[g-1];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) sck_prev <= 1'b0;
        else     sck_prev <= chain[STAGES-1][1];
    end

    always_comb begin
        evt.sel  = ~chain[STAGES-1][2];
        evt.rise = chain[STAGES-1][1] & ~sck_prev;
        evt.fall = ~chain[STAGES-1][1] & sck_prev;
        evt.din  = chain[STAGES-1][0];
    end
endmodule

// File: rtl/spi_sram_array.sv
module spi_sram_array #(
    parameter int WORD_W = 8,
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [WORD_W-1:0] wdata,
    output logic [WORD_W-1:0] rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [WORD_W-1:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        if (we) cells[addr] <= wdata;
        rdata <= cells[addr];
    end
endmodule

// File: rtl/spi_sram_engine.sv
module spi_sram_engine
    import spi_sram_pkg::*;
#(
    parameter int WORD_W = 8,
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  pin_evt_t          evt,
    input  logic [WORD_W-1:0] mem_rdata,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [WORD_W-1:0] mem_wdata,
    output phase_e            phase_o,
    output logic              so,
    output logic              so_oe
);
    localparam int ABITS = 8 * addr_field_bytes(ADDR_W);
    localparam int SH_W  = max3(ABITS, WORD_W, 8);
    localparam int CNT_W = $clog2(SH_W + 1);

    phase_e            phase;
    logic [CNT_W-1:0]  cnt;
    logic [7:0]        cmd;
    logic [SH_W-1:0]   shreg;
    logic [SH_W-1:0]   shin;
    logic [ADDR_W-1:0] ptr;
    logic              past_top;
    logic [WORD_W-1:0] tx;
    logic [WORD_W-1:0] load_word;
    logic              so_q;
    logic              word_done;

    assign shin      = {shreg[SH_W-2:0], evt.din};
    assign word_done = (cnt == CNT_W'(WORD_W - 1));
    assign load_word = past_top ? '0 : mem_rdata;

    always_comb begin
        mem_we    = evt.sel && evt.rise && (phase == PH_WDATA) && word_done && !past_top;
        mem_wdata = shin[WORD_W-1:0];
        mem_addr  = ptr;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase    <= PH_CMD;
            cnt      <= '0;
            cmd      <= '0;
            shreg    <= '0;
            ptr      <= '0;
            past_top <= 1'b0;
            tx       <= '0;
            so_q     <= 1'b0;
        end else if (!evt.sel) begin
            phase    <= PH_CMD;
            cnt      <= '0;
            past_top <= 1'b0;
            so_q     <= 1'b0;
        end else begin
            if (evt.rise) begin
                shreg <= shin;
                cnt   <= cnt + CNT_W'(1);
                unique case (phase)
                    PH_CMD: begin
                        if (cnt == CNT_W'(7)) begin
                            cnt   <= '0;
                            cmd   <= shin[7:0];
                            phase <= cmd_known(shin[7:0]) ? PH_ADDR : PH_IGNORE;
                        end
                    end
                    PH_ADDR: begin
                        if (cnt == CNT_W'(ABITS - 1)) begin
                            cnt <= '0;
                            ptr <= shin[ADDR_W-1:0];
                            if (cmd == CMD_FREAD)      phase <= PH_DUMMY;
                            else if (cmd == CMD_WRITE) phase <= PH_WDATA;
                            else                       phase <= PH_RDATA;
                        end
                    end
                    PH_DUMMY: begin
                        if (cnt == CNT_W'(7)) begin
                            cnt   <= '0;
                            phase <= PH_RDATA;
                        end
                    end
                    PH_RDATA, PH_WDATA: begin
                        if (word_done) begin
                            cnt <= '0;
                            if (ptr == '1) past_top <= 1'b1;
                            else           ptr <= ptr + ADDR_W'(1);
                        end
                    end
                    default: cnt <= '0;
                endcase
            end
            if (evt.fall) begin
                if (phase == PH_RDATA) begin
                    if (cnt == '0) begin
                        so_q <= load_word[WORD_W-1];
                        tx   <= load_word << 1;
                    end else begin
                        so_q <= tx[WORD_W-1];
                        tx   <= tx << 1;
                    end
                end else begin
                    so_q <= 1'b0;
                end
            end
        end
    end

    assign phase_o = phase;
    assign so      = so_q;
    assign so_oe   = evt.sel;
endmodule

// File: rtl/spi_sram_target.sv
module spi_sram_target
    import spi_sram_pkg::*;
#(
    parameter int WORD_W = 8,
    parameter int ADDR_W = 10,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic spi_cs_n,
    input  logic spi_sck,
    input  logic spi_si,
    output logic spi_so,
    output logic spi_so_oe
);
    pin_evt_t          evt;
    logic              mem_we;
    logic [ADDR_W-1:0] mem_addr;
    logic [WORD_W-1:0] mem_wdata;
    logic [WORD_W-1:0] mem_rdata;
    phase_e            phase;

    spi_sram_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst  (rst),
        .sck  (spi_sck),
        .cs_n (spi_cs_n),
        .si   (spi_si),
        .evt  (evt)
    );

    spi_sram_engine #(.WORD_W(WORD_W), .ADDR_W(ADDR_W)) u_engine (
        .clk       (clk),
        .rst       (rst),
        .evt       (evt),
        .mem_rdata (mem_rdata),
        .mem_we    (mem_we),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .phase_o   (phase),
        .so        (spi_so),
        .so_oe     (spi_so_oe)
    );

    spi_sram_array #(.WORD_W(WORD_W), .ADDR_W(ADDR_W)) u_array (
        .clk   (clk),
        .we    (mem_we),
        .addr  (mem_addr),
        .wdata (mem_wdata),
        .rdata (mem_rdata)
    );
endmodule

// File: rtl/spi_sram_target_chk.sv
module spi_sram_target_chk
    import spi_sram_pkg::*;
#(
    parameter int ADDR_W = 10
) (
    input logic              clk,
    input logic              rst,
    input logic              spi_cs_n,
    input logic              spi_so,
    input logic              spi_so_oe,
    input logic              sel,
    input logic              fall,
    input phase_e            phase,
    input logic              mem_we,
    input logic [ADDR_W-1:0] mem_addr
);
    logic [2:0] settle;

    always_ff @(posedge clk) begin
        if (rst)                settle <= '0;
        else if (settle != 3'd7) settle <= settle + 3'd1;
    end

    AST_DESELECT_RELEASES_SO: assert property (@(posedge clk) disable iff (rst)
        (settle >= 3'd4 && spi_cs_n && $past(spi_cs_n) && $past(spi_cs_n, 2)) |-> !spi_so_oe); // R7

    AST_SELECT_DRIVES_SO: assert property (@(posedge clk) disable iff (rst)
        (settle >= 3'd4 && !spi_cs_n && !$past(spi_cs_n) && !$past(spi_cs_n, 2)) |-> spi_so_oe); // R7

    AST_SO_MOVES_AFTER_FALL: assert property (@(posedge clk) disable iff (rst)
        (sel && $past(sel) && !$stable(spi_so)) |-> $past(fall)); // R8

    AST_WRITE_ONLY_IN_WDATA: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> (phase == PH_WDATA)); // R3

    AST_IGNORE_IS_STICKY: assert property (@(posedge clk) disable iff (rst)
        (sel && phase == PH_IGNORE) |=> (phase == PH_IGNORE || !sel)); // R2

    AST_POINTER_STEPS_BY_ONE: assert property (@(posedge clk) disable iff (rst)
        (sel && $past(sel) && phase == $past(phase) &&
         (phase == PH_RDATA || phase == PH_WDATA))
        |-> (mem_addr == $past(mem_addr) || mem_addr == $past(mem_addr) + ADDR_W'(1))); // R4
endmodule

bind spi_sram_target spi_sram_target_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .spi_cs_n  (spi_cs_n),
    .spi_so    (spi_so),
    .spi_so_oe (spi_so_oe),
    .sel       (evt.sel),
    .fall      (evt.fall),
    .phase     (phase),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr)
);

// File: tb/test_spi_sram_target.sv
module test_spi_sram_target;
    localparam int HALF = 5;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic spi_cs_n = 1'b1;
    logic spi_sck = 1'b0;
    logic spi_si = 1'b0;
    logic spi_so;
    logic spi_so_oe;

    int n_checks = 0;
    int n_fail = 0;
    int unstable = 0;
    logic [7:0] exp_val [$];
    string      exp_tag [$];
    logic [7:0] obs_val [$];

    always #10 clk = ~clk;

    spi_sram_target i_spi_sram_target (
        .clk       (clk),
        .rst       (rst),
        .spi_cs_n  (spi_cs_n),
        .spi_sck   (spi_sck),
        .spi_si    (spi_si),
        .spi_so    (spi_so),
        .spi_so_oe (spi_so_oe)
    );

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got 0x%0h expected 0x%0h", tag, got, exp);
        end
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    // One SCK cycle: drive SI, sample SO just before the rise and before the fall
    task automatic sbit(input logic b, output logic r);
        logic r2;
        spi_si = b;
        repeat (HALF) @(negedge clk);
        r = spi_so;
        spi_sck = 1'b1;
        repeat (HALF) @(negedge clk);
        r2 = spi_so;
        if (r2 !== r) unstable++;
        spi_sck = 1'b0;
    endtask

    task automatic sbyte(input logic [7:0] tx, output logic [7:0] rx);
        for (int i = 7; i >= 0; i--) sbit(tx[i], rx[i]);
    endtask

    task automatic select();
        @(negedge clk);
        spi_cs_n = 1'b0;
        repeat (HALF) @(negedge clk);
    endtask

    task automatic deselect();
        repeat (HALF) @(negedge clk);
        spi_cs_n = 1'b1;
        repeat (3 * HALF) @(negedge clk);
    endtask

    task automatic header(input logic [7:0] op, input logic [15:0] a);
        logic [7:0] d;
        sbyte(op, d);
        sbyte(a[15:8], d);
        sbyte(a[7:0], d);
    endtask

    task automatic write_seq(input logic [15:0] a, input logic [7:0] d0, input logic [7:0] d1,
                             input logic [7:0] d2, input logic [7:0] d3, input int n);
        logic [7:0] data [4];
        logic [7:0] d;
        data[0] = d0; data[1] = d1; data[2] = d2; data[3] = d3;
        select();
        header(8'h02, a);
        for (int i = 0; i < n; i++) sbyte(data[i], d);
        deselect();
    endtask

    // Driver: push what the requirements predict, then clock the bytes out
    task automatic expect_byte(input logic [7:0] v, input string tag);
        exp_val.push_back(v);
        exp_tag.push_back(tag);
    endtask

    task automatic read_bytes(input int n);
        logic [7:0] d;
        for (int i = 0; i < n; i++) begin
            sbyte(8'h00, d);
            obs_val.push_back(d);
        end
    endtask

    // Monitor: pairs each observed byte with the next expected item
    initial begin
        forever begin
            @(negedge clk);
            while (obs_val.size() > 0) begin
                if (exp_val.size() == 0) begin
                    check("unexpected byte", obs_val.pop_front(), 32'hFFFF);
                end else begin
                    check(exp_tag.pop_front(), obs_val.pop_front(), exp_val.pop_front());
                end
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        logic [7:0] d;
        logic [7:0] acc;
        logic       r;

        repeat (4) @(negedge clk);
        rst = 1'b0;
        repeat (4) @(negedge clk);
        check("R11 so_oe after reset", spi_so_oe, 0);
        check("R11 so after reset", spi_so, 0);

        select();
        check("R7 so_oe while selected", spi_so_oe, 1);
        deselect();
        check("R7 so_oe after deselect", spi_so_oe, 0);

        // R3 / R4: sequential write then sequential plain read (R5)
        write_seq(16'h0020, 8'h11, 8'h22, 8'h33, 8'h44, 4);
        select();
        header(8'h03, 16'h0020);
        expect_byte(8'h11, "R5 read first word");
        expect_byte(8'h22, "R4 read increments");
        expect_byte(8'h33, "R3 write stored word 3");
        expect_byte(8'h44, "R4 fourth word");
        read_bytes(4);
        deselect();

        // R6: one dummy byte for the fast read
        select();
        header(8'h0B, 16'h0021);
        sbyte(8'h00, d);
        expect_byte(8'h22, "R6 fast read first word");
        expect_byte(8'h33, "R6 fast read second word");
        read_bytes(2);
        deselect();

        // R1: upper address bits ignored
        write_seq(16'hFC05, 8'h5A, 8'h00, 8'h00, 8'h00, 1);
        select();
        header(8'h03, 16'h0005);
        expect_byte(8'h5A, "R1 upper address bits ignored");
        read_bytes(1);
        deselect();

        // R9: run past the top of the array
        write_seq(16'h0000, 8'h77, 8'h00, 8'h00, 8'h00, 1);
        write_seq(16'h03FE, 8'hC1, 8'hC2, 8'hC3, 8'h00, 3);
        select();
        header(8'h03, 16'h03FE);
        expect_byte(8'hC1, "R9 word at 0x3FE");
        expect_byte(8'hC2, "R9 last word written");
        expect_byte(8'h00, "R9 read past top is zero");
        expect_byte(8'h00, "R9 still zero");
        read_bytes(4);
        deselect();
        select();
        header(8'h03, 16'h0000);
        expect_byte(8'h77, "R9 no wrap to location 0");
        read_bytes(1);
        deselect();

        // R10: abort in the middle of a write word
        select();
        header(8'h02, 16'h0020);
        for (int i = 0; i < 4; i++) sbit(1'b1, r);
        deselect();
        // R10: abort in the middle of a command byte
        select();
        for (int i = 0; i < 5; i++) sbit(1'b1, r);
        deselect();
        select();
        header(8'h03, 16'h0020);
        expect_byte(8'h11, "R10 partial write discarded");
        read_bytes(1);
        deselect();

        // R2: unknown command ignored
        select();
        header(8'h05, 16'h0020);
        acc = 8'h00;
        for (int i = 0; i < 3; i++) begin
            sbyte(8'hEE, d);
            acc = acc | d;
        end
        check("R2 SO held low on unknown command", acc, 0);
        deselect();
        select();
        header(8'h03, 16'h0020);
        expect_byte(8'h11, "R2 memory untouched by unknown command");
        read_bytes(1);
        deselect();

        repeat (4) @(negedge clk);
        check("R8 SO stable across high SCK phases", unstable, 0);
        check("R4 all expected words observed", exp_val.size(), 0);
        finish_run();
    end
endmodule